// File: doc/BRIEF.md
# Up-Counting Timer with Input Capture

This block is a free-running binary up-counter with one capture register, reached over a small byte-wide register port. Software starts and stops the count with a run bit. A write to the preset register while the count is halted zeroes the counter. The live count and the captured value are each read as a low byte and a high byte.

A capture copies the live count into the capture register. Two sources can start one. The first is a rising edge on an external pin, which passes through a two-stage synchronizer first. The second is any bus write to either capture byte address; the written byte is thrown away. Every capture raises a one-cycle interrupt pulse and sets a sticky status flag, which software clears by writing 1 to it. Reading the low count byte freezes the high byte in a holding register, so the following high-byte read belongs to the same 16-bit sample.

Top module: `capture_timer`

## Requirements
- R1: While the run bit (bit 0 at address 0) is 1, the 16-bit counter adds one on every clock. After 0xFFFF it wraps to 0x0000.
- R2: While the run bit is 0, the counter holds its value.
- R3: A write of any data to preset address 2 (low byte) or 3 (high byte) while the run bit is 0 sets the counter to 0x0000 on that edge. The preset bytes read back what was written.
- R4: A preset write while the run bit is 1 changes only the preset register. The counter keeps counting.
- R5: Read data is combinational from the address. Address 4 returns the live low count byte. A read of address 4 also copies the live high count byte into a holding register on that edge. Address 5 returns the holding register.
- R6: A rising edge on cap_pin is passed through two synchronizing flip-flops and then captures the count. A falling edge starts no capture.
- R7: A write to address 6 or 7 starts a capture. The written data never reaches the capture register. The capture register reads as low byte at address 6 and high byte at address 7.
- R8: Each capture drives cap_irq high for exactly one clock and sets status bit 0 at address 1. Writing 1 to that bit clears it. Writing 0 leaves it unchanged.
- R9: After reset the run bit is 0, the status bit is 0 and cap_irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| cap_pin | input | 1 | Asynchronous external capture input |
| cap_irq | output | 1 | One-cycle pulse on every capture |

## Verification
The bench uses the default build: a 16-bit counter, 8-bit bytes and a two-stage synchronizer. With 16 bits, a full pass from 0x0000 through 0xFFFF fits inside the run. This lets the bench reach the real wrap and read the high byte from the holding register exactly as the count rolls over. With two sync stages, the pin-to-capture latency is short and fixed, so a capture taken while the timer is halted has one known expected value.

// File: rtl/capture_timer_pkg.sv
package capture_timer_pkg;

  // Register offsets; capture bytes sit at adjacent addresses so either
  // address decodes as a capture trigger.
  typedef enum logic [2:0] {
    RA_CTRL    = 3'd0,
    RA_STATUS  = 3'd1,
    RA_PRE_LO  = 3'd2,
    RA_PRE_HI  = 3'd3,
    RA_CNT_LO  = 3'd4,
    RA_CNT_HI  = 3'd5,
    RA_CAP_LO  = 3'd6,
    RA_CAP_HI  = 3'd7
  } reg_addr_e;

  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned DONE_BIT = 0;

  function automatic logic is_preset(input logic [2:0] a);
    return (a == RA_PRE_LO) || (a == RA_PRE_HI);
  endfunction

  function automatic logic is_capture(input logic [2:0] a);
    return (a == RA_CAP_LO) || (a == RA_CAP_HI);
  endfunction

endpackage

// File: rtl/capture_timer_sync.sv
module capture_timer_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_rise
);

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= 1'b0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign pin_rise = chain_q[STAGES-1] & ~last_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_rise |=> !pin_rise); // R6

endmodule

// File: rtl/capture_timer_counter.sv
module capture_timer_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             preset_wr,
  output logic [CNT_W-1:0] count
);

  logic             clear_evt;
  logic [CNT_W-1:0] count_q;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  assign clear_evt = preset_wr & ~run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count_q <= '0;
    else if (clear_evt) count_q <= '0;
    else if (run)       count_q <= step(count_q);
  end

  assign count = count_q;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (count == step($past(count)))); // R1
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !preset_wr) |=> $stable(count)); // R2
  AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && preset_wr) |=> (count == '0)); // R3
  AST_RUN_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    (run && preset_wr) |=> (count == step($past(count)))); // R4

endmodule

// File: rtl/capture_timer_capture.sv
module capture_timer_capture #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             hw_trig,
  input  logic             sw_trig,
  input  logic             done_clr,
  output logic [CNT_W-1:0] cap_value,
  output logic             done_flag,
  output logic             irq_pulse
);

  logic             cap_fire;
  logic [CNT_W-1:0] cap_q;
  logic             done_q;
  logic             irq_q;

  assign cap_fire = hw_trig | sw_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap_q <= '0;
    else if (cap_fire) cap_q <= count;
  end

  // A new capture in the same cycle as a clear keeps the flag set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_q <= 1'b0;
    else if (cap_fire) done_q <= 1'b1;
    else if (done_clr) done_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= cap_fire;
  end

  assign cap_value = cap_q;
  assign done_flag = done_q;
  assign irq_pulse = irq_q;

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (cap_value == $past(count))); // R7
  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> $stable(cap_value)); // R7
  AST_IRQ_MARKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> done_flag); // R8
  AST_IRQ_FROM_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(cap_fire)); // R8

endmodule

// File: rtl/capture_timer_regs.sv
module capture_timer_regs
  import capture_timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [CNT_W-1:0]  cap_value,
  input  logic              done_flag,
  output logic              run,
  output logic              preset_wr,
  output logic              sw_trig,
  output logic              done_clr
);

  localparam int unsigned HI_W = CNT_W - BYTE_W;

  logic              wr_en;
  logic              rd_en;
  logic              ctrl_wr;
  logic              hold_load;
  logic              run_q;
  logic [CNT_W-1:0]  preset_q;
  logic [HI_W-1:0]   hold_q;

  function automatic logic [BYTE_W-1:0] lo_byte(input logic [CNT_W-1:0] v);
    return v[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] hi_byte(input logic [CNT_W-1:0] v);
    return v[CNT_W-1 -: BYTE_W];
  endfunction

  assign wr_en     = bus_sel & bus_wr;
  assign rd_en     = bus_sel & ~bus_wr;
  assign ctrl_wr   = wr_en & (bus_addr == RA_CTRL);
  assign preset_wr = wr_en & is_preset(bus_addr);
  assign sw_trig   = wr_en & is_capture(bus_addr);
  assign done_clr  = wr_en & (bus_addr == RA_STATUS) & bus_wdata[DONE_BIT];
  assign hold_load = rd_en & (bus_addr == RA_CNT_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= 1'b0;
    else if (ctrl_wr) run_q <= bus_wdata[RUN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preset_q <= '0;
    end else if (wr_en && bus_addr == RA_PRE_LO) begin
      preset_q[BYTE_W-1:0] <= bus_wdata;
    end else if (wr_en && bus_addr == RA_PRE_HI) begin
      preset_q[CNT_W-1 -: BYTE_W] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= '0;
    else if (hold_load) hold_q <= count[CNT_W-1:BYTE_W];
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      RA_CTRL:   bus_rdata[RUN_BIT]  = run_q;
      RA_STATUS: bus_rdata[DONE_BIT] = done_flag;
      RA_PRE_LO: bus_rdata = lo_byte(preset_q);
      RA_PRE_HI: bus_rdata = hi_byte(preset_q);
      RA_CNT_LO: bus_rdata = lo_byte(count);
      RA_CNT_HI: bus_rdata = hold_q[BYTE_W-1:0];
      RA_CAP_LO: bus_rdata = lo_byte(cap_value);
      RA_CAP_HI: bus_rdata = hi_byte(cap_value);
      default:   bus_rdata = '0;
    endcase
  end

  assign run = run_q;

  AST_HOLD_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_load |=> (hold_q == $past(count[CNT_W-1:BYTE_W]))); // R5
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_load |=> $stable(hold_q)); // R5
  AST_RUN_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(run)); // R1

endmodule

// File: rtl/capture_timer.sv
module capture_timer #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              cap_pin,
  output logic              cap_irq
);

  logic             run;
  logic             preset_wr;
  logic             sw_trig;
  logic             hw_trig;
  logic             done_clr;
  logic             done_flag;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cap_value;

  capture_timer_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .count     (count),
    .cap_value (cap_value),
    .done_flag (done_flag),
    .run       (run),
    .preset_wr (preset_wr),
    .sw_trig   (sw_trig),
    .done_clr  (done_clr)
  );

  capture_timer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .preset_wr (preset_wr),
    .count     (count)
  );

  capture_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (cap_pin),
    .pin_rise  (hw_trig)
  );

  capture_timer_capture #(.CNT_W(CNT_W)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .hw_trig   (hw_trig),
    .sw_trig   (sw_trig),
    .done_clr  (done_clr),
    .cap_value (cap_value),
    .done_flag (done_flag),
    .irq_pulse (cap_irq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !cap_irq); // R9

endmodule

// File: tb/capture_timer_bench.sv
module capture_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cap_pin = 1'b0;
  logic       cap_irq;

  int checks = 0;
  int errors = 0;
  int irq_cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  capture_timer u_capture_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .cap_irq(cap_irq)
  );

  always @(negedge clk) if (cap_irq) irq_cycles++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd0, v); check("R9 run bit", v, 0);
    rd(3'd1, v); check("R9 status", v, 0);
    check("R9 cap_irq", cap_irq, 0);
  endtask

  task automatic t_run_stop();
    logic [7:0] v;
    wr(3'd2, 8'h00);            // clear while stopped
    wr(3'd0, 8'h01);            // count 0 at return
    repeat (7) @(negedge clk);  // count 7
    wr(3'd0, 8'h00);            // last increment -> 8
    rd(3'd4, v); check("R1 count after 8 clocks", v, 8);
    repeat (10) @(negedge clk);
    rd(3'd4, v); check("R2 halted count lo", v, 8);
    rd(3'd5, v); check("R2 halted count hi", v, 0);
  endtask

  task automatic t_clear();
    logic [7:0] v;
    wr(3'd2, 8'h34);
    rd(3'd4, v); check("R3 cleared lo", v, 0);
    rd(3'd5, v); check("R3 cleared hi", v, 0);
    wr(3'd3, 8'h12);
    rd(3'd2, v); check("R3 preset lo readback", v, 8'h34);
    rd(3'd3, v); check("R3 preset hi readback", v, 8'h12);
  endtask

  task automatic t_preset_running();
    logic [7:0] v;
    wr(3'd0, 8'h01);            // run set, count stays 0
    wr(3'd2, 8'h77);            // running preset, count -> 1
    wr(3'd0, 8'h00);            // count -> 2, stop
    rd(3'd4, v); check("R4 count untouched by preset", v, 2);
    rd(3'd2, v); check("R4 preset stored", v, 8'h77);
  endtask

  task automatic t_sw_capture();
    logic [7:0] v;
    int irq0;
    irq0 = irq_cycles;
    wr(3'd7, 8'hA5);
    @(negedge clk);
    rd(3'd6, v); check("R7 sw capture lo", v, 2);
    rd(3'd7, v); check("R7 write data ignored", v, 0);
    check("R8 one irq cycle", irq_cycles - irq0, 1);
    rd(3'd1, v); check("R8 status set", v, 1);
    wr(3'd1, 8'h00);
    rd(3'd1, v); check("R8 write 0 keeps status", v, 1);
    wr(3'd1, 8'h01);
    rd(3'd1, v); check("R8 write 1 clears status", v, 0);
    // running capture: count value of the cycle of the write
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h01);
    repeat (5) @(negedge clk);
    wr(3'd6, 8'hFF);            // captures 5, count -> 6
    wr(3'd0, 8'h00);            // count -> 7, stop
    rd(3'd6, v); check("R7 running capture lo", v, 5);
    rd(3'd7, v); check("R7 running capture hi", v, 0);
    wr(3'd1, 8'h01);
  endtask

  task automatic t_pin();
    logic [7:0] v;
    int irq0;
    irq0 = irq_cycles;
    cap_pin = 1;
    repeat (6) @(negedge clk);
    rd(3'd6, v); check("R6 pin rise capture", v, 7);
    check("R6 pin irq single", irq_cycles - irq0, 1);
    rd(3'd1, v); check("R8 status from pin", v, 1);
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h01);
    wr(3'd0, 8'h00);            // count 8
    irq0 = irq_cycles;
    cap_pin = 0;
    repeat (6) @(negedge clk);
    rd(3'd6, v); check("R6 falling edge ignored", v, 7);
    check("R6 no irq on fall", irq_cycles - irq0, 0);
    rd(3'd1, v); check("R6 status untouched on fall", v, 0);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h01);            // count 0
    repeat (65535) @(negedge clk);
    rd(3'd4, v); check("R1 count lo at 0xFFFF", v, 8'hFF);
    rd(3'd5, v); check("R5 held hi byte across wrap", v, 8'hFF);
    rd(3'd4, v); check("R1 wrapped count lo", v, 8'h01);
    rd(3'd5, v); check("R5 held hi after wrap", v, 8'h00);
    wr(3'd0, 8'h00);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_run_stop();
    t_clear();
    t_preset_running();
    t_sw_capture();
    t_pin();
    t_wrap();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

endmodule